// File: doc/BRIEF.md
# Operand Stack Input Unit

This block holds the operand stack of a stack-machine datapath and carries out the four operations that bring new values onto it: pushing an immediate operand, pushing the current stack depth as data, taking one value from a side advice queue, and taking a four-element word from that queue. The sixteen shallowest positions live in registers and are all visible at the ports. An operation is offered with a valid/ready handshake and takes effect at the clock edge on which the handshake completes. The new stack contents, depth and error flag are registered.

Each operation that pushes a value moves every existing element one place deeper. The element that leaves the deepest visible slot is saved in an overflow LIFO, and a depth register counts every element on the stack, including those spilled. The window starts filled with zeros, so the depth never reads below the window size. The word operation replaces the four shallowest slots in place and leaves the depth alone. The advice queue is read through a port that offers its first four elements in parallel, together with how many of them are valid. The block reports how many it consumed in the same cycle. An advice operation that needs more elements than the queue holds is refused: it raises an error flag and changes nothing.

Top module: `osa_operand_stack`

## Requirements
- R1: After reset every visible slot is 0, the depth equals the window size (16), `err` is 0 and `spill_top` is 0.
- R2: An accepted immediate push (op code 0) writes `op_imm` to slot 0, moves each slot i to slot i+1, and increments the depth by one.
- R3: An accepted depth push (op code 1) writes the depth held before the operation, zero-extended, to slot 0, shifts like R2 and increments the depth.
- R4: An accepted single advice pop (op code 2) with `adv_level` at least 1 writes advice element 0 (bits W-1:0 of `adv_head`) to slot 0, shifts like R2, increments the depth and drives `adv_pop` to 1 in the same cycle.
- R5: An accepted word advice pop (op code 3) with `adv_level` equal to 4 writes advice element k (bits k*W +: W) to slot k for k = 0..3, leaves slots 4 and deeper and the depth unchanged, and drives `adv_pop` to 4 in the same cycle.
- R6: An advice pop that finds fewer valid elements than it needs (fewer than 1 for op code 2, fewer than 4 for op code 3) drives `adv_pop` to 0, leaves the slots and depth unchanged, and makes `err` 1 for the following cycle only.
- R7: On every shifting operation the element leaving slot 15 is stored in the overflow LIFO; `spill_top` shows the most recently stored element, or 0 while the LIFO is empty.
- R8: When the depth equals 16 plus the overflow capacity, `op_ready` is 0 and an offered operation changes no slot, depth or flag.
- R9: With `op_valid` low, `adv_pop` is 0 and the slots, depth and `spill_top` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The block can accept an operation |
| op_code | input | 2 | 0 push immediate, 1 push depth, 2 advice pop one, 3 advice pop word |
| op_imm | input | W | Immediate operand for op code 0 |
| adv_head | input | 4*W | First four advice queue elements, element 0 in the low bits |
| adv_level | input | 3 | Count of valid elements in `adv_head` (0 to 4) |
| adv_pop | output | 3 | Elements removed from the advice queue this cycle |
| tos | output | 16*W | Visible slots, slot 0 in the low bits |
| depth | output | DW | Total stack depth |
| spill_top | output | W | Most recently spilled element |
| err | output | 1 | Refused advice pop in the previous cycle |

## Verification
`op_ready` and `adv_pop` are combinational and due in the cycle the operation is offered. The bench drives inputs after a falling edge and samples those two outputs shortly after, before the rising edge. The slots, depth, `spill_top` and `err` change at the rising edge that accepts the operation, so they are compared at the next falling edge against a queue-based model that is advanced once per edge. This means that every result is checked exactly one register stage after its stimulus.

// File: rtl/osa_pkg.sv
package osa_pkg;
   typedef enum logic [1:0] {
      OP_PUSH_IMM   = 2'b00,
      OP_PUSH_DEPTH = 2'b01,
      OP_ADV_ONE    = 2'b10,
      OP_ADV_WORD   = 2'b11
   } osa_op_e;

   localparam int unsigned WORD_ELEMS = 4;
   localparam int unsigned LEVEL_W    = 3;
endpackage

// File: rtl/osa_op_decode.sv
module osa_op_decode
   import osa_pkg::*;
(
   input  logic                 op_valid,
   input  logic [1:0]           op_code,
   input  logic [LEVEL_W-1:0]   adv_level,
   input  logic                 store_full,
   output logic                 op_ready,
   output logic                 do_shift,
   output logic                 do_word,
   output logic                 do_refuse,
   output logic [LEVEL_W-1:0]   adv_pop
);
   logic               fire;
   logic [LEVEL_W-1:0] need;
   logic               short_q;

   always_comb begin
      unique case (osa_op_e'(op_code))
         OP_ADV_ONE:  need = LEVEL_W'(1);
         OP_ADV_WORD: need = LEVEL_W'(WORD_ELEMS);
         default:     need = '0;
      endcase
   end

   assign op_ready  = !store_full;
   assign fire      = op_valid && op_ready;
   assign short_q   = adv_level < need;
   assign do_refuse = fire && short_q;
   assign do_word   = fire && !short_q && (osa_op_e'(op_code) == OP_ADV_WORD);
   assign do_shift  = fire && !short_q && (osa_op_e'(op_code) != OP_ADV_WORD);
   assign adv_pop   = (fire && !short_q) ? need : '0;
endmodule

// File: rtl/osa_shift_window.sv
module osa_shift_window
   import osa_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned WINDOW = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        do_shift,
   input  logic                        do_word,
   input  logic [W-1:0]                push_val,
   input  logic [WORD_ELEMS*W-1:0]     word_in,
   output logic [WINDOW*W-1:0]         slots,
   output logic [W-1:0]                leaving
);
   logic [W-1:0] slot_q [WINDOW];

   for (genvar i = 0; i < WINDOW; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)        slot_q[i] <= '0;
            else if (do_shift) slot_q[i] <= push_val;
            else if (do_word)  slot_q[i] <= word_in[0 +: W];
         end
      end else if (i < WORD_ELEMS) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)        slot_q[i] <= '0;
            else if (do_shift) slot_q[i] <= slot_q[i-1];
            else if (do_word)  slot_q[i] <= word_in[i*W +: W];
         end
      end else begin : g_deep
         always_ff @(posedge clk) begin
            if (!rst_n)        slot_q[i] <= '0;
            else if (do_shift) slot_q[i] <= slot_q[i-1];
         end
      end
      assign slots[i*W +: W] = slot_q[i];
   end

   assign leaving = slot_q[WINDOW-1];
endmodule

// File: rtl/osa_depth_ctr.sv
module osa_depth_ctr #(
   parameter int unsigned WINDOW    = 16,
   parameter int unsigned OVF_DEPTH = 8,
   parameter int unsigned DW        = 5,
   parameter int unsigned PW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [DW-1:0] depth,
   output logic [PW-1:0] spill_cnt,
   output logic          full
);
   localparam logic [DW-1:0] FLOOR = DW'(WINDOW);
   localparam logic [DW-1:0] CEIL  = DW'(WINDOW + OVF_DEPTH);

   logic [DW-1:0] depth_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               depth_q <= FLOOR;
      else if (inc && !full)    depth_q <= depth_q + DW'(1);
   end

   assign depth     = depth_q;
   assign full      = (depth_q == CEIL);
   assign spill_cnt = PW'(depth_q - FLOOR);
endmodule

// File: rtl/osa_spill_lifo.sv
module osa_spill_lifo #(
   parameter int unsigned W         = 32,
   parameter int unsigned OVF_DEPTH = 8,
   parameter int unsigned PW        = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [PW-1:0] cnt,
   input  logic [W-1:0]  wr_data,
   output logic [W-1:0]  top_data
);
   logic [W-1:0] ent_q [OVF_DEPTH];

   for (genvar k = 0; k < OVF_DEPTH; k++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)                            ent_q[k] <= '0;
         else if (wr_en && cnt == PW'(k))       ent_q[k] <= wr_data;
      end
   end

   always_comb begin
      top_data = '0;
      for (int k = 0; k < OVF_DEPTH; k++) begin
         if (cnt == PW'(k + 1)) top_data = ent_q[k];
      end
   end
endmodule

// File: rtl/osa_operand_stack.sv
module osa_operand_stack
   import osa_pkg::*;
#(
   parameter int unsigned W         = 32,
   parameter int unsigned WINDOW    = 16,
   parameter int unsigned OVF_DEPTH = 8,
   localparam int unsigned DW       = $clog2(WINDOW + OVF_DEPTH + 1),
   localparam int unsigned PW       = $clog2(OVF_DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     op_valid,
   output logic                     op_ready,
   input  logic [1:0]               op_code,
   input  logic [W-1:0]             op_imm,
   input  logic [WORD_ELEMS*W-1:0]  adv_head,
   input  logic [LEVEL_W-1:0]       adv_level,
   output logic [LEVEL_W-1:0]       adv_pop,
   output logic [WINDOW*W-1:0]      tos,
   output logic [DW-1:0]            depth,
   output logic [W-1:0]             spill_top,
   output logic                     err
);
   if (W < DW) begin : g_bad_width
      $error("osa_operand_stack: W must hold the depth value");
   end
   if (WINDOW < WORD_ELEMS) begin : g_bad_window
      $error("osa_operand_stack: WINDOW must cover a whole word");
   end
   if (OVF_DEPTH < 1) begin : g_bad_ovf
      $error("osa_operand_stack: OVF_DEPTH must be at least 1");
   end

   logic          do_shift, do_word, do_refuse, full;
   logic [W-1:0]  push_val, leaving;
   logic [PW-1:0] spill_cnt;
   logic          err_q;

   osa_op_decode u_dec (
      .op_valid  (op_valid),
      .op_code   (op_code),
      .adv_level (adv_level),
      .store_full(full),
      .op_ready  (op_ready),
      .do_shift  (do_shift),
      .do_word   (do_word),
      .do_refuse (do_refuse),
      .adv_pop   (adv_pop)
   );

   always_comb begin
      unique case (osa_op_e'(op_code))
         OP_PUSH_IMM:   push_val = op_imm;
         OP_PUSH_DEPTH: push_val = W'(depth);
         default:       push_val = adv_head[0 +: W];
      endcase
   end

   osa_shift_window #(.W(W), .WINDOW(WINDOW)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_shift(do_shift),
      .do_word (do_word),
      .push_val(push_val),
      .word_in (adv_head),
      .slots   (tos),
      .leaving (leaving)
   );

   osa_depth_ctr #(.WINDOW(WINDOW), .OVF_DEPTH(OVF_DEPTH), .DW(DW), .PW(PW)) u_depth (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (do_shift),
      .depth    (depth),
      .spill_cnt(spill_cnt),
      .full     (full)
   );

   osa_spill_lifo #(.W(W), .OVF_DEPTH(OVF_DEPTH), .PW(PW)) u_spill (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (do_shift),
      .cnt     (spill_cnt),
      .wr_data (leaving),
      .top_data(spill_top)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= do_refuse;
   end
   assign err = err_q;
endmodule

// File: rtl/osa_operand_stack_chk.sv
module osa_operand_stack_chk #(
   parameter int unsigned W         = 32,
   parameter int unsigned WINDOW    = 16,
   parameter int unsigned OVF_DEPTH = 8,
   parameter int unsigned DW        = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic                op_ready,
   input logic [1:0]          op_code,
   input logic [W-1:0]        op_imm,
   input logic [2:0]          adv_level,
   input logic [2:0]          adv_pop,
   input logic [WINDOW*W-1:0] tos,
   input logic [DW-1:0]       depth,
   input logic                err
);
   logic fire;
   assign fire = op_valid && op_ready;

   assert_depth_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      depth >= DW'(WINDOW));

   assert_push_imm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op_code == 2'd0 |=> tos[W-1:0] == $past(op_imm) && depth == $past(depth) + DW'(1));

   assert_pop_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv_pop == 3'd1 |-> op_valid && op_code == 2'd2 && adv_level >= 3'd1);

   assert_word_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op_code == 2'd3 && adv_level >= 3'd4 |=> $stable(depth) && !err);

   assert_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire && op_code == 2'd3 && adv_level < 3'd4 |=> err && $stable(tos) && $stable(depth));

   assert_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      depth == DW'(WINDOW + OVF_DEPTH) |-> !op_ready);

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> adv_pop == 3'd0 ##1 $stable(tos));
endmodule

bind osa_operand_stack osa_operand_stack_chk #(
   .W(W), .WINDOW(WINDOW), .OVF_DEPTH(OVF_DEPTH), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
   .op_code(op_code), .op_imm(op_imm), .adv_level(adv_level), .adv_pop(adv_pop),
   .tos(tos), .depth(depth), .err(err)
);

// File: tb/osa_operand_stack_tb.sv
`timescale 1ns/1ps
module osa_operand_stack_tb;
   localparam int W = 32;
   localparam int WIN = 16;
   localparam int OVF = 24;
   localparam int DW = $clog2(WIN + OVF + 1);

   logic clk = 0;
   logic rst_n = 0;
   logic op_valid = 0;
   logic op_ready;
   logic [1:0] op_code = 0;
   logic [W-1:0] op_imm = 0;
   logic [4*W-1:0] adv_head = 0;
   logic [2:0] adv_level = 0;
   logic [2:0] adv_pop;
   logic [WIN*W-1:0] tos;
   logic [DW-1:0] depth;
   logic [W-1:0] spill_top;
   logic err;

   always #4 clk = ~clk;

   osa_operand_stack #(.W(W), .WINDOW(WIN), .OVF_DEPTH(OVF)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_imm(op_imm), .adv_head(adv_head), .adv_level(adv_level),
      .adv_pop(adv_pop), .tos(tos), .depth(depth), .spill_top(spill_top), .err(err)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model
   logic [W-1:0] m_slot [WIN];
   int m_depth;
   logic [W-1:0] m_spill [$];
   bit m_err;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_state(input string req);
      bit ok = 1;
      int bad = 0;
      for (int i = 0; i < WIN; i++)
         if (tos[i*W +: W] !== m_slot[i]) begin ok = 0; bad = i; end
      check(ok, req, "slot", 64'(tos[bad*W +: W]), 64'(m_slot[bad]));
      check(depth === DW'(m_depth), req, "depth", 64'(depth), 64'(m_depth));
      check(err === m_err, req, "err", 64'(err), 64'(m_err));
      check(spill_top === ((m_spill.size() == 0) ? '0 : m_spill[$]), req, "spill_top",
            64'(spill_top), 64'((m_spill.size() == 0) ? '0 : m_spill[$]));
   endtask

   task automatic step(input string req, input bit v, input logic [1:0] code,
                       input logic [W-1:0] imm, input logic [2:0] lvl,
                       input logic [W-1:0] h0, input logic [W-1:0] h1,
                       input logic [W-1:0] h2, input logic [W-1:0] h3);
      bit exp_ready, fire, shortq;
      int need, exp_pop;
      logic [W-1:0] pv;
      op_valid = v; op_code = code; op_imm = imm; adv_level = lvl;
      adv_head = {h3, h2, h1, h0};
      #1;
      exp_ready = (m_spill.size() < OVF);
      need = (code == 2'd2) ? 1 : (code == 2'd3) ? 4 : 0;
      fire = v && exp_ready;
      shortq = int'(lvl) < need;
      exp_pop = (fire && !shortq) ? need : 0;
      check(op_ready === exp_ready, req, "op_ready", 64'(op_ready), 64'(exp_ready));
      check(adv_pop === 3'(exp_pop), req, "adv_pop", 64'(adv_pop), 64'(exp_pop));
      m_err = fire && shortq;
      if (fire && !shortq) begin
         if (code == 2'd3) begin
            m_slot[0] = h0; m_slot[1] = h1; m_slot[2] = h2; m_slot[3] = h3;
         end else begin
            pv = (code == 2'd0) ? imm : (code == 2'd1) ? W'(m_depth) : h0;
            m_spill.push_back(m_slot[WIN-1]);
            for (int i = WIN - 1; i > 0; i--) m_slot[i] = m_slot[i-1];
            m_slot[0] = pv;
            m_depth++;
         end
      end
      @(posedge clk);
      @(negedge clk);
      op_valid = 0;
      compare_state(req);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < WIN; i++) m_slot[i] = '0;
      m_depth = WIN;
      m_err = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare_state("R1");

      step("R9", 0, 2'd0, 32'hDEAD, 3'd4, 1, 2, 3, 4);
      step("R2", 1, 2'd0, 32'h11, 3'd0, 0, 0, 0, 0);
      step("R2", 1, 2'd0, 32'h22, 3'd0, 0, 0, 0, 0);
      step("R3", 1, 2'd1, 32'hFFFF, 3'd0, 0, 0, 0, 0);
      step("R4", 1, 2'd2, 0, 3'd3, 32'hA0, 32'hA1, 32'hA2, 0);
      step("R5", 1, 2'd3, 0, 3'd4, 32'hB0, 32'hB1, 32'hB2, 32'hB3);
      step("R6", 1, 2'd3, 0, 3'd3, 32'hC0, 32'hC1, 32'hC2, 32'hC3);
      step("R6", 1, 2'd2, 0, 3'd0, 32'hD0, 0, 0, 0);
      step("R9", 0, 2'd2, 0, 3'd4, 32'hE0, 0, 0, 0);
      step("R4", 1, 2'd2, 0, 3'd1, 32'hE1, 0, 0, 0);
      step("R3", 1, 2'd1, 0, 3'd4, 0, 0, 0, 0);
      for (int n = 0; n < 20; n++) begin
         if (n % 3 == 0) step("R7", 1, 2'd1, 0, 3'd0, 0, 0, 0, 0);
         else            step("R7", 1, 2'd0, 32'h100 + n, 3'd0, 0, 0, 0, 0);
      end
      step("R8", 1, 2'd0, 32'h5A5A, 3'd4, 0, 0, 0, 0);
      step("R8", 1, 2'd3, 0, 3'd4, 32'hF0, 32'hF1, 32'hF2, 32'hF3);
      step("R9", 0, 2'd0, 0, 3'd0, 0, 0, 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule